// File: doc/BRIEF.md
# Byte FIFO with Threshold-Driven Transfer Requests

This block holds a 256-byte data FIFO between a bus side (CPU or DMA) and a flash-memory side. It watches the FIFO fill level and raises two request lines, one toward the CPU as an interrupt and one toward a DMA engine. A two-bit trigger code and a direction bit choose the thresholds. When the flash is being read, the block counts the bytes stored in the FIFO. When the flash is being programmed, it counts the free bytes instead. Some codes give the two requests different thresholds. Some codes forbid DMA altogether while programming.

Both requests are level signals. Each is formed from the registered fill level and the registered configuration, and each has its own enable. A request drops in the same cycle that the level moves out of its range. A new code, a new direction or a new enable applies from the next clock edge. The block also carries a small address counter that belongs to a companion FIFO. Software can force that counter to zero by holding a clear input high.

Top module: `fifo_req_gen`

## Requirements
- R1: After reset, level_o is 0, free_o is 256, empty_o is 1 and full_o is 0. Both requests are 0, err_o is 0 and ecc_addr_o is 0.
- R2: An accepted push stores push_data_i. An accepted pop removes the oldest byte, which pop_data_o shows while the FIFO is not empty. level_o counts the stored bytes (0 to 256) and free_o always equals 256 minus level_o.
- R3: When push_i and pop_i are both high and the FIFO is neither full nor empty, both operations take effect and level_o does not change.
- R4: A push while full_o is 1, or a pop while empty_o is 1, is ignored and sets err_o. err_o then stays at 1 until reset.
- R5: In read direction (dir_prog_i = 0), codes 2'b00, 2'b01 and 2'b10 raise both requests when level_o is at least 4, 16 and 128 respectively.
- R6: In read direction with code 2'b11, irq_req_o needs level_o of at least 128 and dma_req_o needs level_o of at least 16.
- R7: In program direction (dir_prog_i = 1), code 2'b00 raises irq_req_o at free_o of at least 4, and code 2'b10 does so at free_o of at least 128. dma_req_o stays 0 for both codes.
- R8: In program direction, code 2'b01 raises both requests at free_o of at least 16. Code 2'b11 raises irq_req_o at free_o of at least 128 and dma_req_o at free_o of at least 16.
- R9: irq_req_o is 0 while the registered irq_en_i is 0, and dma_req_o is 0 while the registered dma_en_i is 0. When the level leaves a request's range, that request falls in the same cycle that level_o changes.
- R10: dir_prog_i, trig_sel_i, irq_en_i and dma_en_i are sampled at a clock edge. They act only after that edge, and no earlier request is remembered.
- R11: While ecc_clr_i is 1, ecc_addr_o becomes 0 at the next edge and stays 0. While ecc_clr_i is 0, ecc_addr_o increments on each edge where ecc_adv_i is 1 and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_prog_i | input | 1 | 1 = program direction (count free bytes), 0 = read direction (count stored bytes) |
| trig_sel_i | input | 2 | Trigger code |
| irq_en_i | input | 1 | Interrupt request enable |
| dma_en_i | input | 1 | DMA request enable |
| push_i | input | 1 | Write one byte into the FIFO |
| push_data_i | input | 8 | Byte to write |
| pop_i | input | 1 | Remove the oldest byte |
| pop_data_o | output | 8 | Oldest stored byte |
| level_o | output | 9 | Stored byte count |
| free_o | output | 9 | Free byte count |
| full_o | output | 1 | FIFO holds 256 bytes |
| empty_o | output | 1 | FIFO holds no bytes |
| irq_req_o | output | 1 | Interrupt request level |
| dma_req_o | output | 1 | DMA request level |
| err_o | output | 1 | Sticky overflow/underflow flag |
| ecc_adv_i | input | 1 | Advance the companion address counter |
| ecc_clr_i | input | 1 | Hold the companion address counter at zero |
| ecc_addr_o | output | 6 | Companion address counter |

## Verification
The hardest conditions to reach are the program-direction thresholds, because they only show at low free space. Free space of 4, 16 and 128 bytes means 252, 240 and 128 bytes stored, and an overflow needs all 256 bytes stored. The stimulus pushes the FIFO up through a list of levels that sit on both sides of every threshold, including full. At each level it walks through all eight direction and code pairs and compares both requests with a model. It then drains the FIFO while a scoreboard checks the byte order, and it checks that a request falls as soon as a pop takes the level below its threshold.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;
  typedef enum logic [1:0] {
    TRIG_LO    = 2'b00,
    TRIG_MID   = 2'b01,
    TRIG_HI    = 2'b10,
    TRIG_SPLIT = 2'b11
  } trig_sel_e;

  typedef struct packed {
    logic      prog;
    trig_sel_e sel;
    logic      irq_en;
    logic      dma_en;
  } trig_cfg_t;
endpackage

// File: rtl/byte_fifo_store.sv
module byte_fifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              err_q;
  logic              push_ok, pop_ok;

  assign full_o  = (lvl_q == LVL_W'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      if (push_ok && !pop_ok)      lvl_q <= lvl_q + 1'b1;
      else if (pop_ok && !push_ok) lvl_q <= lvl_q - 1'b1;
      if ((push_i && full_o) || (pop_i && empty_o)) err_q <= 1'b1;
    end
  end

  assign data_o  = mem_q[rd_q];
  assign level_o = lvl_q;
  assign err_o   = err_q;
endmodule

// File: rtl/trig_decode.sv
module trig_decode
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int TH_LO  = 4,
  parameter int TH_MID = 16,
  parameter int TH_HI  = 128,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  trig_cfg_t        cfg_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             irq_o,
  output logic             dma_o
);
  logic [LVL_W-1:0] meas;
  logic ge_lo, ge_mid, ge_hi;
  logic irq_raw, dma_raw;

  // program direction measures free space, read direction measures fill
  assign meas   = cfg_i.prog ? (LVL_W'(DEPTH) - level_i) : level_i;
  assign ge_lo  = meas >= LVL_W'(TH_LO);
  assign ge_mid = meas >= LVL_W'(TH_MID);
  assign ge_hi  = meas >= LVL_W'(TH_HI);

  always_comb begin
    unique case (cfg_i.sel)
      TRIG_LO:    begin irq_raw = ge_lo;  dma_raw = ge_lo  & ~cfg_i.prog; end
      TRIG_MID:   begin irq_raw = ge_mid; dma_raw = ge_mid;               end
      TRIG_HI:    begin irq_raw = ge_hi;  dma_raw = ge_hi  & ~cfg_i.prog; end
      default:    begin irq_raw = ge_hi;  dma_raw = ge_mid;               end
    endcase
  end

  assign irq_o = irq_raw & cfg_i.irq_en;
  assign dma_o = dma_raw & cfg_i.dma_en;
endmodule

// File: rtl/ecc_addr_ctr.sv
module ecc_addr_ctr #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign addr_o = cnt_q;
endmodule

// File: rtl/fifo_req_gen.sv
module fifo_req_gen
  import fifo_trig_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int TH_LO  = 4,
  parameter int TH_MID = 16,
  parameter int TH_HI  = 128,
  parameter int ECC_AW = 6,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_prog_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              irq_en_i,
  input  logic              dma_en_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [LVL_W-1:0]  free_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              irq_req_o,
  output logic              dma_req_o,
  output logic              err_o,
  input  logic              ecc_adv_i,
  input  logic              ecc_clr_i,
  output logic [ECC_AW-1:0] ecc_addr_o
);
  trig_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '{prog: 1'b0, sel: TRIG_LO, irq_en: 1'b0, dma_en: 1'b0};
    else         cfg_q <= '{prog: dir_prog_i, sel: trig_sel_e'(trig_sel_i),
                            irq_en: irq_en_i, dma_en: dma_en_i};
  end

  byte_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .data_i  (push_data_i),
    .pop_i   (pop_i),
    .data_o  (pop_data_o),
    .level_o (level_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .err_o   (err_o)
  );

  assign free_o = LVL_W'(DEPTH) - level_o;

  trig_decode #(.DEPTH(DEPTH), .TH_LO(TH_LO), .TH_MID(TH_MID), .TH_HI(TH_HI)) dec_i (
    .cfg_i   (cfg_q),
    .level_i (level_o),
    .irq_o   (irq_req_o),
    .dma_o   (dma_req_o)
  );

  ecc_addr_ctr #(.AW(ECC_AW)) ecc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ecc_clr_i),
    .adv_i  (ecc_adv_i),
    .addr_o (ecc_addr_o)
  );
endmodule

// File: rtl/fifo_req_gen_chk.sv
module fifo_req_gen_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int ECC_AW = 6,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dir_prog_i,
  input logic [1:0]        trig_sel_i,
  input logic              irq_en_i,
  input logic              dma_en_i,
  input logic              push_i,
  input logic              pop_i,
  input logic [LVL_W-1:0]  level_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              irq_req_o,
  input logic              dma_req_o,
  input logic              err_o,
  input logic              ecc_clr_i,
  input logic [ECC_AW-1:0] ecc_addr_o
);
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH)); // R2
  AST_PUSH_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o) |=> $stable(level_o)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> ($stable(level_o) && err_o)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> ($stable(level_o) && err_o)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R4
  AST_PROG_DMA_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_prog_i && !trig_sel_i[0]) |=> !dma_req_o); // R7
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !irq_req_o); // R9
  AST_DMA_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |=> !dma_req_o); // R9
  AST_ECC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_clr_i |=> (ecc_addr_o == '0)); // R11
endmodule

bind fifo_req_gen fifo_req_gen_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ECC_AW(ECC_AW)) chk_i (.*);

// File: tb/fifo_req_gen_tb_top.sv
module fifo_req_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_prog = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic       irq_en = 1'b0, dma_en = 1'b0;
  logic       push = 1'b0, pop = 1'b0;
  logic [7:0] push_data = '0;
  logic [7:0] pop_data;
  logic [8:0] level, free;
  logic       full, empty, irq_req, dma_req, err;
  logic       ecc_adv = 1'b0, ecc_clr = 1'b0;
  logic [5:0] ecc_addr;

  int   n_tests = 0, n_fail = 0;
  bit   done = 0;
  logic [7:0] exp_q [$];
  logic [7:0] seed = 8'h5a;

  always #5 clk = ~clk;

  fifo_req_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dir_prog_i(dir_prog), .trig_sel_i(trig_sel),
    .irq_en_i(irq_en), .dma_en_i(dma_en), .push_i(push), .push_data_i(push_data),
    .pop_i(pop), .pop_data_o(pop_data), .level_o(level), .free_o(free),
    .full_o(full), .empty_o(empty), .irq_req_o(irq_req), .dma_req_o(dma_req),
    .err_o(err), .ecc_adv_i(ecc_adv), .ecc_clr_i(ecc_clr), .ecc_addr_o(ecc_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare of popped data (R2)
  always @(posedge clk) begin
    if (rst_n && pop && !empty) begin
      if (exp_q.size() == 0) chk("R2 pop with empty scoreboard", 1, 0);
      else chk("R2 pop data order", int'(pop_data), int'(exp_q.pop_front()));
    end
  end

  function automatic bit model_req(bit prog, bit [1:0] code, int lvl, bit is_dma);
    int m = prog ? 256 - lvl : lvl;
    case (code)
      2'b00:   return (prog && is_dma) ? 1'b0 : (m >= 4);
      2'b01:   return m >= 16;
      2'b10:   return (prog && is_dma) ? 1'b0 : (m >= 128);
      default: return is_dma ? (m >= 16) : (m >= 128);
    endcase
  endfunction

  task automatic set_cfg(input bit p, input bit [1:0] c, input bit ie, input bit de);
    @(negedge clk);
    dir_prog = p; trig_sel = c; irq_en = ie; dma_en = de;
    @(negedge clk);
  endtask

  task automatic push_one();
    @(negedge clk);
    seed = seed * 8'd5 + 8'd17;
    push = 1'b1; push_data = seed;
    if (!full) exp_q.push_back(seed);
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic pop_one();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic fill_to(input int target);
    while (int'(level) < target) push_one();
  endtask

  task automatic drain_to(input int target);
    while (int'(level) > target) pop_one();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lv[12] = '{0, 3, 4, 15, 16, 127, 128, 240, 241, 252, 253, 256};
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 free", free, 256);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 irq", irq_req, 0);
    chk("R1 dma", dma_req, 0);
    chk("R1 err", err, 0);
    chk("R1 ecc_addr", ecc_addr, 0);

    // threshold sweep over both directions and all codes (R5..R8)
    foreach (lv[i]) begin
      fill_to(lv[i]);
      chk("R2 level count", level, lv[i]);
      chk("R2 free count", free, 256 - lv[i]);
      for (int d = 0; d < 2; d++) begin
        for (int c = 0; c < 4; c++) begin
          string tag;
          set_cfg(d[0], c[1:0], 1'b1, 1'b1);
          if (d == 0) tag = (c == 3) ? "R6" : "R5";
          else        tag = (c == 0 || c == 2) ? "R7" : "R8";
          chk({tag, " irq"}, irq_req, int'(model_req(d[0], c[1:0], lv[i], 1'b0)));
          chk({tag, " dma"}, dma_req, int'(model_req(d[0], c[1:0], lv[i], 1'b1)));
        end
      end
    end
    chk("R2 full flag", full, 1);

    // R4 push when full
    push_one();
    chk("R4 level after full push", level, 256);
    chk("R4 err after full push", err, 1);

    // R9 enables
    set_cfg(1'b0, 2'b00, 1'b0, 1'b1);
    chk("R9 irq gated", irq_req, 0);
    chk("R9 dma enabled", dma_req, 1);
    set_cfg(1'b0, 2'b00, 1'b1, 1'b0);
    chk("R9 irq enabled", irq_req, 1);
    chk("R9 dma gated", dma_req, 0);

    // R9 immediate fall when level drops below threshold
    drain_to(16);
    set_cfg(1'b0, 2'b01, 1'b1, 1'b1);
    chk("R5 dma at 16", dma_req, 1);
    pop_one();
    chk("R2 level after pop", level, 15);
    chk("R9 dma falls with level", dma_req, 0);
    chk("R9 irq falls with level", irq_req, 0);

    // R10 config change acts after the edge
    set_cfg(1'b0, 2'b00, 1'b1, 1'b1);
    chk("R10 irq with code 00", irq_req, 1);
    @(negedge clk);
    trig_sel = 2'b10;
    #1;
    chk("R10 irq before edge", irq_req, 1);
    @(negedge clk);
    chk("R10 irq after edge", irq_req, 0);
    chk("R10 dma after edge", dma_req, 0);

    // R3 simultaneous push and pop
    @(negedge clk);
    seed = seed + 8'd3;
    push = 1'b1; pop = 1'b1; push_data = seed;
    exp_q.push_back(seed);
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
    chk("R3 level unchanged", level, 15);
    drain_to(0);
    chk("R2 empty after drain", empty, 1);
    chk("R2 scoreboard empty", exp_q.size(), 0);

    // R4 pop when empty, after reset clears err
    do_reset();
    chk("R1 err after reset", err, 0);
    pop_one();
    chk("R4 level after empty pop", level, 0);
    chk("R4 err after empty pop", err, 1);
    push_one();
    chk("R4 err sticky", err, 1);
    chk("R2 level after push", level, 1);
    pop_one();

    // R11 companion counter
    @(negedge clk); ecc_adv = 1'b1;
    repeat (3) @(negedge clk);
    ecc_adv = 1'b0;
    chk("R11 advance", ecc_addr, 3);
    repeat (2) @(negedge clk);
    chk("R11 hold", ecc_addr, 3);
    ecc_clr = 1'b1; ecc_adv = 1'b1;
    @(negedge clk);
    chk("R11 cleared", ecc_addr, 0);
    @(negedge clk);
    chk("R11 held clear", ecc_addr, 0);
    ecc_clr = 1'b0;
    @(negedge clk);
    ecc_adv = 1'b0;
    chk("R11 resume", ecc_addr, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule